// File: doc/BRIEF.md
# Auxiliary Memory DMA Engine

This block copies data between main memory and a separate auxiliary memory in 8-byte beats. Software sets a 32-bit main-memory address, a 32-bit auxiliary-memory address and a 32-bit count word. The top bit of the count word selects the direction and the remaining 31 bits give a byte count. Each register can be reached as two 16-bit halves or as one 32-bit access at the high-half offset. A write that sets the low part of the count starts the copy. The engine then runs one beat at a time. Each beat reads 64 bits from the source port and writes that word to the destination port on the next cycle. When the count is used up, the engine raises a one-cycle completion pulse. The interrupt logic outside the block uses this pulse to set its pending flag.

A 6-bit size field gives how much auxiliary memory is fitted. The field is in units of 64 KiB by default. A beat whose auxiliary address is at or above that limit is dropped. It makes no memory access and both addresses stay where they are, but the count still goes down by 8. A runaway transfer therefore always ends and never touches memory that does not exist. Three housekeeping registers (size, mode and refresh) are kept next to the DMA registers and hold fixed reset values.

Top module: `aux_dma_engine`

## Requirements
- R1: After reset the size register (offset 0x12) reads 0, the mode register (0x16) reads 1, the refresh register (0x1A) reads 156, the three DMA registers read 0, and busy and done are low.
- R2: Register offsets are 0x20/0x22 for the main address (high/low half), 0x24/0x26 for the auxiliary address and 0x28/0x2A for the count. A 16-bit write to one half changes only that half. A 32-bit access at a high-half offset covers the whole register, with the high half in bits 31:16.
- R3: When count bit 31 is 0, each beat asserts the main read enable. On the next cycle it asserts the auxiliary write enable and writes the word that main memory returned, so main-memory data lands in auxiliary memory.
- R4: When count bit 31 is 1, each beat reads the auxiliary port and then writes the returned word to the main port, so auxiliary-memory data lands in main memory.
- R5: A 16-bit write to offset 0x2A, or a 32-bit write to offset 0x28, starts a transfer. A 16-bit write to offset 0x28 alone does not start one.
- R6: Each beat that is performed adds 8 to both addresses and subtracts 8 from the count. At the end, the address registers read their start values plus the bytes moved, and the count field reads 0 with bit 31 unchanged.
- R7: The auxiliary limit is the size field (bits 5:0 of 0x12) shifted left by SIZE_SHIFT. A beat whose auxiliary address is at or above the limit makes no memory access and takes one cycle. It leaves both addresses unchanged, and the count still drops by 8.
- R8: The low 3 bits of a started count are dropped. A count below 8 makes no memory access and gives the done pulse on the cycle after the start write.
- R9: Busy is high from the cycle after the start write until the last beat ends. Done is high for exactly one cycle, in the first cycle where busy is low again. A performed beat takes 2 cycles and a skipped beat takes 1 cycle.
- R10: While busy is high, writes to the main address, auxiliary address and count registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| reg_wdata | input | 32 | Write data (16-bit writes use bits 15:0) |
| reg_rdata | output | 32 | Read data for reg_addr |
| busy | output | 1 | Transfer running |
| done | output | 1 | One-cycle completion pulse |
| mm_addr | output | 32 | Main-memory byte address |
| mm_rd_en | output | 1 | Main-memory read; data is expected on the next cycle |
| mm_rdata | input | 64 | Main-memory read data |
| mm_wr_en | output | 1 | Main-memory write |
| mm_wdata | output | 64 | Main-memory write data |
| ar_addr | output | 32 | Auxiliary-memory byte address |
| ar_rd_en | output | 1 | Auxiliary-memory read; data is expected on the next cycle |
| ar_rdata | input | 64 | Auxiliary-memory read data |
| ar_wr_en | output | 1 | Auxiliary-memory write |
| ar_wdata | output | 64 | Auxiliary-memory write data |

## Verification
The bench runs a transfer that crosses the auxiliary limit part way through. A design that stopped at the limit would never raise done, and one that still advanced the addresses would leave them at the wrong values. It starts counts that are not multiples of 8 or are smaller than 8, where a design without rounding would run one beat too many or hang with the count never reaching zero. It writes only the high half of the count to show that this does not start a transfer. It writes the address registers during a run, where a design without the lock would jump to another address. Cycle counts per transfer also expose a skip that wrongly takes two cycles, or a done pulse placed on the wrong cycle.

// File: rtl/aux_dma_engine.sv
module aux_dma_engine #(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int OW         = 8,
  parameter int SIZE_SHIFT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_wide,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mm_addr,
  output logic          mm_rd_en,
  input  logic [DW-1:0] mm_rdata,
  output logic          mm_wr_en,
  output logic [DW-1:0] mm_wdata,
  output logic [AW-1:0] ar_addr,
  output logic          ar_rd_en,
  input  logic [DW-1:0] ar_rdata,
  output logic          ar_wr_en,
  output logic [DW-1:0] ar_wdata
);
  localparam int          STEP      = DW / 8;
  localparam int          LW        = AW + 1;
  localparam logic [OW-1:0] OFF_INFO = OW'('h12);
  localparam logic [OW-1:0] OFF_MODE = OW'('h16);
  localparam logic [OW-1:0] OFF_REFR = OW'('h1A);
  localparam logic [OW-1:0] OFF_MM_H = OW'('h20);
  localparam logic [OW-1:0] OFF_MM_L = OW'('h22);
  localparam logic [OW-1:0] OFF_AR_H = OW'('h24);
  localparam logic [OW-1:0] OFF_AR_L = OW'('h26);
  localparam logic [OW-1:0] OFF_CN_H = OW'('h28);
  localparam logic [OW-1:0] OFF_CN_L = OW'('h2A);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;

  state_t      st_q;
  logic [15:0] info_q, mode_q, refr_q;
  logic [31:0] mm_q, ar_q;
  logic        dir_q;
  logic [30:0] cnt_q;
  logic        done_q;

  logic        wr16, wr32, start, in_range, last;
  logic [31:0] cnt_view, cnt_new;
  logic [LW-1:0] limit;

  assign wr16     = reg_wr && !reg_wide;
  assign wr32     = reg_wr && reg_wide;
  assign cnt_view = {dir_q, cnt_q};
  assign cnt_new  = wr32 ? reg_wdata : {cnt_view[31:16], reg_wdata[15:0]};
  assign start    = (st_q == S_IDLE) &&
                    ((wr16 && reg_addr == OFF_CN_L) || (wr32 && reg_addr == OFF_CN_H));
  assign limit    = LW'(info_q[5:0]) << SIZE_SHIFT;
  assign in_range = {1'b0, ar_q} < limit;
  assign last     = (cnt_q == 31'(STEP));

  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;
  assign mm_addr  = mm_q;
  assign ar_addr  = ar_q;
  assign mm_rd_en = (st_q == S_RD) && in_range && !dir_q;
  assign ar_rd_en = (st_q == S_RD) && in_range &&  dir_q;
  assign ar_wr_en = (st_q == S_WR) && !dir_q;
  assign mm_wr_en = (st_q == S_WR) &&  dir_q;
  assign mm_wdata = ar_rdata;
  assign ar_wdata = mm_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      info_q <= '0;
      mode_q <= 16'd1;
      refr_q <= 16'd156;
      mm_q   <= '0;
      ar_q   <= '0;
      dir_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wr16) begin
        if (reg_addr == OFF_INFO) info_q <= reg_wdata[15:0];
        if (reg_addr == OFF_MODE) mode_q <= reg_wdata[15:0];
        if (reg_addr == OFF_REFR) refr_q <= reg_wdata[15:0];
      end
      case (st_q)
        S_IDLE: begin
          if (wr16) begin
            if (reg_addr == OFF_MM_H) mm_q[31:16] <= reg_wdata[15:0];
            if (reg_addr == OFF_MM_L) mm_q[15:0]  <= reg_wdata[15:0];
            if (reg_addr == OFF_AR_H) ar_q[31:16] <= reg_wdata[15:0];
            if (reg_addr == OFF_AR_L) ar_q[15:0]  <= reg_wdata[15:0];
            if (reg_addr == OFF_CN_H) {dir_q, cnt_q[30:16]} <= reg_wdata[15:0];
          end
          if (wr32) begin
            if (reg_addr == OFF_MM_H) mm_q <= reg_wdata;
            if (reg_addr == OFF_AR_H) ar_q <= reg_wdata;
          end
          if (start) begin
            dir_q <= cnt_new[31];
            cnt_q <= {cnt_new[30:3], 3'b000};
            if (cnt_new[30:3] != '0) st_q   <= S_RD;
            else                     done_q <= 1'b1;
          end
        end
        S_RD: begin
          if (in_range) begin
            st_q <= S_WR;
          end else begin
            cnt_q <= cnt_q - 31'(STEP);
            if (last) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        S_WR: begin
          mm_q  <= mm_q + 32'(STEP);
          ar_q  <= ar_q + 32'(STEP);
          cnt_q <= cnt_q - 31'(STEP);
          if (last) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= S_RD;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_INFO: reg_rdata = {16'h0, info_q};
      OFF_MODE: reg_rdata = {16'h0, mode_q};
      OFF_REFR: reg_rdata = {16'h0, refr_q};
      OFF_MM_H: reg_rdata = reg_wide ? mm_q : {16'h0, mm_q[31:16]};
      OFF_MM_L: reg_rdata = {16'h0, mm_q[15:0]};
      OFF_AR_H: reg_rdata = reg_wide ? ar_q : {16'h0, ar_q[31:16]};
      OFF_AR_L: reg_rdata = {16'h0, ar_q[15:0]};
      OFF_CN_H: reg_rdata = reg_wide ? cnt_view : {16'h0, cnt_view[31:16]};
      OFF_CN_L: reg_rdata = {16'h0, cnt_view[15:0]};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/aux_dma_engine_sva.sv
module aux_dma_engine_sva #(
  parameter int AW         = 32,
  parameter int SIZE_SHIFT = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mm_rd_en,
  input logic          mm_wr_en,
  input logic          ar_rd_en,
  input logic          ar_wr_en,
  input logic [AW-1:0] mm_addr,
  input logic [AW-1:0] ar_addr,
  input logic [5:0]    size_fld
);
  logic [AW:0] lim;
  assign lim = (AW+1)'(size_fld) << SIZE_SHIFT;

  assert_main_to_aux_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mm_rd_en |=> ar_wr_en);

  assert_aux_to_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ar_rd_en |=> mm_wr_en);

  assert_one_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mm_rd_en, mm_wr_en, ar_rd_en, ar_wr_en}));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_wr_en || ar_wr_en) |=>
      (mm_addr == $past(mm_addr) + AW'(8)) && (ar_addr == $past(ar_addr) + AW'(8)));

  assert_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_rd_en || ar_rd_en) |-> ({1'b0, ar_addr} < lim));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind aux_dma_engine aux_dma_engine_sva #(.AW(AW), .SIZE_SHIFT(SIZE_SHIFT)) sva_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mm_rd_en(mm_rd_en), .mm_wr_en(mm_wr_en), .ar_rd_en(ar_rd_en), .ar_wr_en(ar_wr_en),
  .mm_addr(mm_addr), .ar_addr(ar_addr), .size_fld(info_q[5:0])
);

// File: tb/aux_dma_engine_tb_top.sv
`timescale 1ns/1ps
module aux_dma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_wide = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, done;
  logic [31:0] mm_addr, ar_addr;
  logic        mm_rd_en, mm_wr_en, ar_rd_en, ar_wr_en;
  logic [63:0] mm_rdata = '0, ar_rdata = '0, mm_wdata, ar_wdata;

  logic [63:0] mm_mem [64];
  logic [63:0] ar_mem [64];
  int          ar_acc = 0;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  aux_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wide(reg_wide),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .mm_addr(mm_addr), .mm_rd_en(mm_rd_en), .mm_rdata(mm_rdata), .mm_wr_en(mm_wr_en),
    .mm_wdata(mm_wdata), .ar_addr(ar_addr), .ar_rd_en(ar_rd_en), .ar_rdata(ar_rdata),
    .ar_wr_en(ar_wr_en), .ar_wdata(ar_wdata)
  );

  always @(posedge clk) begin
    if (mm_rd_en) mm_rdata <= mm_mem[mm_addr[8:3]];
    if (mm_wr_en) mm_mem[mm_addr[8:3]] <= mm_wdata;
    if (ar_rd_en) ar_rdata <= ar_mem[ar_addr[8:3]];
    if (ar_wr_en) ar_mem[ar_addr[8:3]] <= ar_wdata;
    if (ar_rd_en || ar_wr_en) ar_acc <= ar_acc + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic wide);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wide = wide; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wide = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic wide, output logic [31:0] d);
    reg_addr = a; reg_wide = wide;
    #1 d = reg_rdata;
    reg_wide = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 500) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h12, 0, v); check("R1 size", v, 0);
    rd(8'h16, 0, v); check("R1 mode", v, 1);
    rd(8'h1A, 0, v); check("R1 refresh", v, 156);
    rd(8'h20, 1, v); check("R1 main addr", v, 0);
    rd(8'h24, 1, v); check("R1 aux addr", v, 0);
    rd(8'h28, 1, v); check("R1 count", v, 0);
    check("R1 busy/done", {busy, done}, 0);
  endtask

  task automatic t_halves;
    logic [31:0] v;
    wr(8'h20, 32'hAAAA_BBBB, 1);
    wr(8'h22, 32'h0000_1234, 0);
    rd(8'h20, 1, v); check("R2 low half only", v, 32'hAAAA_1234);
    wr(8'h20, 32'h0000_5678, 0);
    rd(8'h20, 1, v); check("R2 high half only", v, 32'h5678_1234);
    rd(8'h22, 0, v); check("R2 16-bit low read", v, 32'h1234);
    wr(8'h28, 32'h0000_0001, 0);
    check("R5 high count write no start", busy, 0);
    rd(8'h28, 1, v); check("R5 count high stored", v, 32'h0001_0000);
    wr(8'h28, 32'h0, 1);
  endtask

  task automatic t_m2a;
    logic [31:0] v; int c;
    wr(8'h12, 32'h43, 0);
    wr(8'h20, 32'h40, 1);
    wr(8'h24, 32'h80, 1);
    wr(8'h28, 32'h20, 1);
    check("R9 busy after start", busy, 1);
    wait_done(c);
    check("R9 cycles 4 beats", c, 8);
    for (int i = 0; i < 4; i++) check("R3 aux gets main data", ar_mem[16+i], mm_mem[8+i]);
    rd(8'h20, 1, v); check("R6 main addr end", v, 32'h60);
    rd(8'h24, 1, v); check("R6 aux addr end", v, 32'hA0);
    rd(8'h28, 1, v); check("R6 count zero", v, 0);
    @(negedge clk); check("R9 done one cycle", done, 0);
  endtask

  task automatic t_a2m;
    logic [31:0] v; int c;
    wr(8'h20, 32'hC0, 1);
    wr(8'h24, 32'h100, 1);
    wr(8'h28, 32'h8000, 0);
    check("R5 high half no start", busy, 0);
    wr(8'h2A, 32'h0018, 0);
    wait_done(c);
    check("R9 cycles 3 beats", c, 6);
    for (int i = 0; i < 3; i++) check("R4 main gets aux data", mm_mem[24+i], ar_mem[32+i]);
    rd(8'h28, 1, v); check("R6 dir kept count zero", v, 32'h8000_0000);
  endtask

  task automatic t_skip;
    logic [31:0] v; int c; int acc0;
    wr(8'h12, 32'h1, 0);
    wr(8'h20, 32'h100, 1);
    wr(8'h24, 32'hFFF0, 1);
    acc0 = ar_acc;
    wr(8'h28, 32'h20, 1);
    wait_done(c);
    check("R7 cycles 2 beats 2 skips", c, 6);
    check("R7 aux accesses", ar_acc - acc0, 2);
    check("R7 beat below limit", ar_mem[62], mm_mem[32]);
    check("R7 beat below limit", ar_mem[63], mm_mem[33]);
    rd(8'h24, 1, v); check("R7 aux addr stops", v, 32'h10000);
    rd(8'h20, 1, v); check("R7 main addr stops", v, 32'h110);
    rd(8'h28, 1, v); check("R7 count drained", v, 0);
    acc0 = ar_acc;
    wr(8'h12, 32'h0, 0);
    wr(8'h24, 32'h0, 1);
    wr(8'h28, 32'h10, 1);
    wait_done(c);
    check("R7 size zero skips all", c, 2);
    check("R7 size zero no access", ar_acc - acc0, 0);
  endtask

  task automatic t_round;
    logic [31:0] v; int c;
    wr(8'h12, 32'h43, 0);
    wr(8'h20, 32'h0, 1);
    wr(8'h24, 32'h0, 1);
    wr(8'h28, 32'h13, 1);
    wait_done(c);
    check("R8 count 19 gives 2 beats", c, 4);
    rd(8'h20, 1, v); check("R8 bytes moved", v, 32'h10);
    wr(8'h28, 32'h5, 1);
    check("R8 count 5 done at once", {busy, done}, 2'b01);
    rd(8'h20, 1, v); check("R8 no beat", v, 32'h10);
  endtask

  task automatic t_lock;
    logic [31:0] v; int c;
    wr(8'h20, 32'h0, 1);
    wr(8'h24, 32'h0, 1);
    wr(8'h28, 32'h40, 1);
    wr(8'h22, 32'h1234, 0);
    wr(8'h2A, 32'h0008, 0);
    wait_done(c);
    check("R10 cycles unchanged", c, 12);
    rd(8'h20, 1, v); check("R10 main addr write ignored", v, 32'h40);
    rd(8'h24, 1, v); check("R10 aux addr", v, 32'h40);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mm_mem[i] = {32'h1111_0000 + 32'(i), 32'hCAFE_0000 + 32'(i)};
      ar_mem[i] = {32'h2222_0000 + 32'(i), 32'hBEEF_0000 + 32'(i)};
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_halves;
    t_m2a;
    t_a2m;
    t_skip;
    t_round;
    t_lock;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule